// File: doc/BRIEF.md
# ISA Extension Register Write Filter

This block holds the writable register that records which instruction-set extensions a hart currently has turned on. Every write attempt passes through a fixed chain of legality rules before anything is stored. Some writes are refused outright. The others are reduced to a combination the hart can actually support.

Each letter-named extension owns one bit, given by its alphabet index (A=0, B=1, ..., Z=25). A two-bit base-width field sits in the top two bits of the register. The stored value appears on a registered output. A registered one-cycle pulse fires whenever the stored value really changes, so that decode or translation caches downstream know to invalidate themselves.

All rules are evaluated combinationally in the cycle of the write. The result lands in the register at the next rising clock edge.

Top module: `isa_feature_filter`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `isa_q` equals the reset value (default 32'h4014_112D: width field 01, plus A, C, D, F, I, M, S and U set) and `isa_changed` is 0.
- R2: When `wr_allow` is 0, a strobed write is ignored and `isa_q` keeps its value.
- R3: A strobed write whose data has neither bit 8 (I) nor bit 4 (E) set is ignored.
- R4: A strobed write whose data has bit 4 (E) set is ignored, so the stored E bit always stays 0.
- R5: On an accepted write, the stored extension bits [25:0] are the written bits ANDed with `impl_mask` and with the supported set {A=0, C=2, D=3, E=4, F=5, I=8, M=12, S=18, U=20}. Bits 29..26 are stored as 0.
- R6: If, after that masking, D (bit 3) is set while F (bit 5) is clear, D is stored as 0.
- R7: If C (bit 2) survives masking and `next_pc_aligned` is 0, C is stored as 0. If `next_pc_aligned` is 1, C is kept.
- R8: The width field, bits [31:30], is never changed by a write.
- R9: `isa_changed` is 1 for exactly the one cycle after an edge at which `isa_q` took a different value. It stays 0 when an accepted write yields the value already stored.
- R10: With `wr_stb` at 0, `isa_q` holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_allow | input | 1 | Configuration enable for writes to the register |
| wr_stb | input | 1 | Write attempt strobe |
| wr_data | input | XLEN | Proposed register value |
| impl_mask | input | 26 | Extensions implemented by this hart, one bit per letter |
| next_pc_aligned | input | 1 | Next instruction address is a multiple of 4 |
| isa_q | output | XLEN | Stored register value |
| isa_changed | output | 1 | One-cycle pulse after the stored value changes |

## Verification
Some properties are checked on every cycle, whatever the stimulus:
- the width field never moves;
- E is never stored;
- D is never stored without F;
- the register holds while writes are disabled or not strobed;
- C is clear after an accepted write made with a misaligned next address;
- no bit outside the implemented mask appears after an accepted write;
- the change pulse matches a change of the register.

Other behaviour is shown only by the bench's scenarios: which writes are refused entirely, the exact value stored after each combination of masks and rules, and the absence of a pulse on a write of the same value. These are checked against an independent model through a scoreboard.

// File: rtl/isa_filt_pkg.sv
package isa_filt_pkg;
  localparam int unsigned EXT_BITS = 26;

  function automatic int unsigned ext_pos(input byte letter);
    return int'(letter) - int'("A");
  endfunction

  localparam int unsigned POS_A = 0;
  localparam int unsigned POS_C = 2;
  localparam int unsigned POS_D = 3;
  localparam int unsigned POS_E = 4;
  localparam int unsigned POS_F = 5;
  localparam int unsigned POS_I = 8;

  function automatic logic [EXT_BITS-1:0] supported_set();
    logic [EXT_BITS-1:0] s;
    byte letters [9];
    letters = '{"I", "E", "M", "A", "F", "D", "C", "S", "U"};
    s = '0;
    foreach (letters[k]) s[ext_pos(letters[k])] = 1'b1;
    return s;
  endfunction

  localparam logic [EXT_BITS-1:0] SUPPORTED = supported_set();
endpackage

// File: rtl/isa_write_gate.sv
module isa_write_gate
  import isa_filt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            wr_allow,
  input  logic            wr_stb,
  input  logic [XLEN-1:0] wr_data,
  output logic            accept
);
  logic has_base_i;
  logic has_base_e;

  assign has_base_i = wr_data[POS_I];
  assign has_base_e = wr_data[POS_E];

  always_comb begin
    accept = wr_stb && wr_allow;
    if (!has_base_i && !has_base_e) accept = 1'b0;
    if (has_base_e)                 accept = 1'b0;
  end
endmodule

// File: rtl/isa_ext_legalize.sv
module isa_ext_legalize
  import isa_filt_pkg::*;
(
  input  logic [EXT_BITS-1:0] raw_ext,
  input  logic [EXT_BITS-1:0] impl_mask,
  input  logic                next_pc_aligned,
  output logic [EXT_BITS-1:0] legal_ext
);
  logic [EXT_BITS-1:0] kept;

  for (genvar b = 0; b < EXT_BITS; b++) begin : g_bit
    if (SUPPORTED[b]) begin : g_sup
      assign kept[b] = raw_ext[b] & impl_mask[b];
    end else begin : g_unsup
      assign kept[b] = 1'b0;
    end
  end

  always_comb begin
    legal_ext = kept;
    if (legal_ext[POS_D] && !legal_ext[POS_F]) legal_ext[POS_D] = 1'b0;
    if (legal_ext[POS_C] && !next_pc_aligned)  legal_ext[POS_C] = 1'b0;
  end
endmodule

// File: rtl/isa_state_reg.sv
module isa_state_reg #(
  parameter int unsigned      XLEN        = 32,
  parameter logic [XLEN-1:0]  RESET_VALUE = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic [XLEN-1:0] next_value,
  output logic [XLEN-1:0] value_q,
  output logic            changed_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value_q   <= RESET_VALUE;
      changed_q <= 1'b0;
    end else begin
      changed_q <= accept && (next_value != value_q);
      if (accept) value_q <= next_value;
    end
  end
endmodule

// File: rtl/isa_feature_filter.sv
module isa_feature_filter
  import isa_filt_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     MXL_W       = 2,
  parameter logic [XLEN-1:0] RESET_VALUE = 32'h4014_112D
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_allow,
  input  logic                wr_stb,
  input  logic [XLEN-1:0]     wr_data,
  input  logic [EXT_BITS-1:0] impl_mask,
  input  logic                next_pc_aligned,
  output logic [XLEN-1:0]     isa_q,
  output logic                isa_changed
);
  localparam int unsigned MID_W = XLEN - MXL_W - EXT_BITS;

  logic                accept;
  logic [EXT_BITS-1:0] legal_ext;
  logic [XLEN-1:0]     next_value;

  isa_write_gate #(.XLEN(XLEN)) u_gate (
    .wr_allow (wr_allow),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .accept   (accept)
  );

  isa_ext_legalize u_legal (
    .raw_ext         (wr_data[EXT_BITS-1:0]),
    .impl_mask       (impl_mask),
    .next_pc_aligned (next_pc_aligned),
    .legal_ext       (legal_ext)
  );

  assign next_value = {isa_q[XLEN-1 -: MXL_W], {MID_W{1'b0}}, legal_ext};

  isa_state_reg #(.XLEN(XLEN), .RESET_VALUE(RESET_VALUE)) u_reg (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .next_value (next_value),
    .value_q    (isa_q),
    .changed_q  (isa_changed)
  );
endmodule

// File: rtl/isa_filter_checker.sv
module isa_filter_checker
  import isa_filt_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned MXL_W = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_allow,
  input logic                wr_stb,
  input logic [XLEN-1:0]     wr_data,
  input logic [EXT_BITS-1:0] impl_mask,
  input logic                next_pc_aligned,
  input logic [XLEN-1:0]     isa_q,
  input logic                isa_changed
);
  logic valid_try;
  assign valid_try = wr_stb && wr_allow && wr_data[POS_I] && !wr_data[POS_E];

  a_r8_width_fixed: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(isa_q[XLEN-1 -: MXL_W]));

  a_r9_pulse_on_change: assert property (@(posedge clk) disable iff (rst)
    isa_changed == (isa_q != $past(isa_q)));

  a_r4_no_e_stored: assert property (@(posedge clk) disable iff (rst)
    !isa_q[POS_E]);

  a_r6_d_needs_f: assert property (@(posedge clk) disable iff (rst)
    isa_q[POS_D] |-> isa_q[POS_F]);

  a_r2_disabled_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_allow |=> $stable(isa_q));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(isa_q));

  a_r7_c_misaligned: assert property (@(posedge clk) disable iff (rst)
    (valid_try && !next_pc_aligned) |=> !isa_q[POS_C]);

  a_r5_within_impl: assert property (@(posedge clk) disable iff (rst)
    valid_try |=> ((isa_q[EXT_BITS-1:0] & ~$past(impl_mask)) == '0));
endmodule

bind isa_feature_filter isa_filter_checker #(.XLEN(XLEN), .MXL_W(MXL_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .wr_allow        (wr_allow),
  .wr_stb          (wr_stb),
  .wr_data         (wr_data),
  .impl_mask       (impl_mask),
  .next_pc_aligned (next_pc_aligned),
  .isa_q           (isa_q),
  .isa_changed     (isa_changed)
);

// File: tb/test_isa_feature_filter.sv
`timescale 1ns/1ps
module test_isa_feature_filter;
  localparam logic [31:0] RST_VAL = 32'h4014_112D;
  localparam logic [25:0] LEGAL   = 26'h014_113D;
  localparam logic [25:0] ALL     = '1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_allow = 1'b0;
  logic        wr_stb = 1'b0;
  logic [31:0] wr_data = '0;
  logic [25:0] impl_mask = '1;
  logic        next_pc_aligned = 1'b1;
  logic [31:0] isa_q;
  logic        isa_changed;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model;

  logic [31:0] q_val [$];
  bit          q_pulse [$];
  string       q_tag [$];

  always #5 clk = ~clk;

  isa_feature_filter i_isa_feature_filter (
    .clk(clk), .rst(rst), .wr_allow(wr_allow), .wr_stb(wr_stb),
    .wr_data(wr_data), .impl_mask(impl_mask),
    .next_pc_aligned(next_pc_aligned), .isa_q(isa_q), .isa_changed(isa_changed)
  );

  function automatic logic [31:0] predict(input logic [31:0] old, input bit stb,
      input bit allow, input logic [31:0] d, input logic [25:0] impl, input bit al);
    logic [25:0] v;
    if (!stb || !allow) return old;
    if (d[4]) return old;
    if (!d[8]) return old;
    v = d[25:0] & impl & LEGAL;
    if (v[3] && !v[5]) v[3] = 1'b0;
    if (v[2] && !al)   v[2] = 1'b0;
    return {old[31:30], 4'b0000, v};
  endfunction

  task automatic op(input bit stb, input bit allow, input logic [31:0] d,
                    input logic [25:0] impl, input bit al, input string tag);
    logic [31:0] nxt;
    @(negedge clk);
    wr_stb = stb; wr_allow = allow; wr_data = d; impl_mask = impl; next_pc_aligned = al;
    nxt = predict(model, stb, allow, d, impl, al);
    @(posedge clk);
    #1;
    q_val.push_back(nxt);
    q_pulse.push_back(nxt != model);
    q_tag.push_back(tag);
    model = nxt;
  endtask

  always @(negedge clk) begin
    if (q_val.size() > 0) begin
      logic [31:0] ev;
      bit ep;
      string t;
      ev = q_val.pop_front(); ep = q_pulse.pop_front(); t = q_tag.pop_front();
      checks++;
      if (isa_q !== ev) begin
        errors++;
        $display("FAIL %s value: actual=%h expected=%h", t, isa_q, ev);
      end
      checks++;
      if (isa_changed !== ep) begin
        errors++;
        $display("FAIL %s R9 pulse: actual=%b expected=%b", t, isa_changed, ep);
      end
    end
  end

  initial begin
    model = RST_VAL;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (isa_q !== RST_VAL || isa_changed !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual=%h/%b expected=%h/0", isa_q, isa_changed, RST_VAL);
    end
    op(1, 1, 32'hFFFF_FFEF, ALL, 1, "R5 R8 R9 all-ones no E, same value");
    op(1, 1, 32'hC000_0100, ALL, 1, "R5 R8 I only");
    op(1, 1, 32'h0000_0028, ALL, 1, "R3 no I no E");
    op(1, 1, 32'h0000_0110, ALL, 1, "R4 E set");
    op(1, 0, 32'h0014_112D, ALL, 1, "R2 writes disabled");
    op(0, 1, 32'h0014_112D, ALL, 1, "R10 no strobe");
    op(1, 1, 32'h0000_1108, ALL, 1, "R6 D without F");
    op(1, 1, 32'h0000_0105, ALL, 0, "R7 C misaligned");
    op(1, 1, 32'h0000_0105, ALL, 1, "R7 C aligned");
    op(1, 1, 32'h0014_112D, ALL & ~26'h000_1000, 1, "R5 impl lacks M");
    op(1, 1, 32'h0000_0128, ALL & ~26'h000_0020, 1, "R6 F masked by impl");
    op(1, 1, 32'h0000_0128, ALL & ~26'h000_0020, 1, "R9 repeat no pulse");
    op(1, 1, 32'h03FF_FFFF & ~32'h10, ALL, 0, "R5 R7 wide write");
    op(0, 0, 32'h0, ALL, 1, "R10 idle tail");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule